// File: doc/BRIEF.md
# Pulse-swallow feedback divider control

This block is the digital half of a pulse-swallow N divider. It is clocked by the output of an external dual-modulus prescaler and steers that prescaler's modulus-select line. Over one divide cycle it lets the prescaler run B periods: the first A of them at modulus P+1 and the rest at P. The feedback ratio seen at the prescaler input is therefore N = B·P + A, and the counters only ever run at the reduced prescaler rate.

The swallow count A (6 bits), the main count B (13 bits) and a 2-bit prescaler mode are taken in only at a divide-cycle boundary. At that boundary the block also latches the prescaler mode that it drives to the prescaler, and sets a sticky-per-cycle error flag when the loaded pair cannot give a valid ratio. A one-period output pulse marks the start of every divide cycle and serves as the divided clock for a downstream phase detector.

Top module: `pls_swallow_div`

## Requirements
- R1: For 1 <= B and A <= B, the distance between successive divide-cycle starts, measured in prescaler input cycles, is B·P + A.
- R2: With a legal pair, mod_sel_o is 1 (select P+1) during exactly the first A prescaler periods of each divide cycle and 0 for the remaining B−A periods.
- R3: A divide cycle lasts B prescaler periods; div_o is 1 only during the first period of each cycle, so with B = 1 it stays 1.
- R4: mode_o selects P: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64; mode_o changes only at a divide-cycle start.
- R5: a_i, b_i and mode_i are sampled only at the prescaler edge that starts a divide cycle; a change in the middle of a cycle leaves that cycle's length unchanged and applies from the next cycle.
- R6: cfg_err_o is 1 for the divide cycle following a load with A > B or B = 0, and 0 after a legal load; it changes only at a divide-cycle start.
- R7: With A > B the swallow is cut short by the cycle end, so mod_sel_o is 1 for all B periods and the ratio is B·(P+1); B = 0 runs as B = 1.
- R8: During reset mod_sel_o, div_o and cfg_err_o are 0 and mode_o is 0; the first prescaler edge after reset starts a divide cycle with the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | A_W (6) | Swallow count A |
| b_i | input | B_W (13) | Main count B |
| mode_i | input | 2 | Requested prescaler mode (R4 encoding) |
| mod_sel_o | output | 1 | 1 selects P+1 for the current prescaler period |
| mode_o | output | 2 | Prescaler mode in force for this divide cycle |
| div_o | output | 1 | High during the first prescaler period of each cycle |
| cfg_err_o | output | 1 | Loaded A/B pair was illegal |

## Verification
The assertions assume the prescaler samples mod_sel_o once per period after the edge that starts it, and that a_i, b_i and mode_i are steady around every clk_i edge; the bench drives them only on the falling edge of the fast input clock, far from the prescaler edges. The prescaler is a behavioural divider in the bench that takes its modulus from mod_sel_o and mode_o, so the measured period depends on both outputs. Every configuration change is followed by at least one discarded divide cycle before its ratio is measured, except in the test that deliberately checks the cycle in flight keeps its old length.

// File: rtl/pls_div_pkg.sv
package pls_div_pkg;
  typedef enum logic [1:0] {
    PSC_DIV8  = 2'd0,
    PSC_DIV16 = 2'd1,
    PSC_DIV32 = 2'd2,
    PSC_DIV64 = 2'd3
  } psc_mode_e;
endpackage

// File: rtl/pls_main_cnt.sv
module pls_main_cnt #(
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [B_W-1:0] b_i,
  output logic           last_o
);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  logic [B_W-1:0] cnt_q;

  // count remaining prescaler periods; reset value forces a load on the first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= B_ONE;
    end else if (last_o) begin
      cnt_q <= (b_i == '0) ? B_ONE : b_i;
    end else begin
      cnt_q <= cnt_q - B_ONE;
    end
  end

  assign last_o = (cnt_q == B_ONE);

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> (cnt_q != '0));
endmodule

// File: rtl/pls_swallow_cnt.sv
module pls_swallow_cnt #(
  parameter int A_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  output logic           mod_sel_o
);
  localparam logic [A_W-1:0] A_ONE = A_W'(1);

  logic [A_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= a_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - A_ONE;
    end
  end

  assign mod_sel_o = (cnt_q != '0);

  // R2
  a_no_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pls_cfg_latch.sv
module pls_cfg_latch
  import pls_div_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  psc_mode_e      mode_i,
  output logic [B_W-1:0] b_len_o,
  output psc_mode_e      mode_o,
  output logic           err_o
);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  logic [B_W-1:0] a_ext;
  logic           bad;

  assign a_ext = B_W'(a_i);
  assign bad   = (a_ext > b_i) || (b_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_len_o <= B_ONE;
      mode_o  <= PSC_DIV8;
      err_o   <= 1'b0;
    end else if (load_i) begin
      b_len_o <= (b_i == '0) ? B_ONE : b_i;
      mode_o  <= mode_i;
      err_o   <= bad;
    end
  end
endmodule

// File: rtl/pls_swallow_div.sv
module pls_swallow_div
  import pls_div_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [1:0]     mode_i,
  output logic           mod_sel_o,
  output logic [1:0]     mode_o,
  output logic           div_o,
  output logic           cfg_err_o
);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  logic           last;
  logic [B_W-1:0] b_len;
  psc_mode_e      mode_q;
  logic           div_q;

  pls_main_cnt #(.B_W(B_W)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .b_i    (b_i),
    .last_o (last)
  );

  pls_swallow_cnt #(.A_W(A_W)) u_swallow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (last),
    .a_i       (a_i),
    .mod_sel_o (mod_sel_o)
  );

  pls_cfg_latch #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .a_i     (a_i),
    .b_i     (b_i),
    .mode_i  (psc_mode_e'(mode_i)),
    .b_len_o (b_len),
    .mode_o  (mode_q),
    .err_o   (cfg_err_o)
  );

  // pulse marks the first prescaler period of the new cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= last;
  end

  assign div_o  = div_q;
  assign mode_o = mode_q;

  // R2
  swallow_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_sel_o) |-> div_o);

  // R3
  div_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> (!div_o || $past(b_len) == B_ONE));

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_o |-> $stable(mode_o));

  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_o |-> $stable(cfg_err_o));
endmodule

// File: tb/pls_swallow_div_tb.sv
module pls_swallow_div_tb;
  logic        rf_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic [5:0]  a_in   = '0;
  logic [12:0] b_in   = 13'd1;
  logic [1:0]  m_in   = '0;
  logic        mod_sel, div, err;
  logic [1:0]  mode_q;

  logic psc_clk = 1'b0;
  logic psc_first = 1'b0;
  int   psc_rem = 0;

  int n_run = 0;
  int n_fail = 0;
  int rf_cnt = 0, sw_cnt = 0, np_cnt = 0;
  int last_period = 0, last_sw = 0, last_np = 0;
  int cyc_done = 0;
  bit started = 1'b0;
  int wd = 0;

  always #4 rf_clk = ~rf_clk;

  pls_swallow_div u_dut (
    .clk_i     (psc_clk),
    .rst_ni    (rst_n),
    .a_i       (a_in),
    .b_i       (b_in),
    .mode_i    (m_in),
    .mod_sel_o (mod_sel),
    .mode_o    (mode_q),
    .div_o     (div),
    .cfg_err_o (err)
  );

  // behavioural dual-modulus prescaler driven by mode_q and mod_sel
  always @(posedge rf_clk) begin
    if (psc_first) begin
      psc_clk   <= 1'b0;
      psc_first <= 1'b0;
      psc_rem   <= (8 << mode_q) + (mod_sel ? 1 : 0) - 2;
    end else if (psc_rem == 0) begin
      psc_clk   <= 1'b1;
      psc_first <= 1'b1;
    end else begin
      psc_rem <= psc_rem - 1;
    end
  end

  // period and swallow measurement, one rf cycle after each prescaler edge
  always @(posedge rf_clk) begin
    rf_cnt <= rf_cnt + 1;
    if (rst_n && psc_clk) begin
      if (div) begin
        if (started) begin
          last_period <= rf_cnt;
          last_sw     <= sw_cnt;
          last_np     <= np_cnt;
          cyc_done    <= cyc_done + 1;
        end
        started <= 1'b1;
        rf_cnt  <= 1;
        sw_cnt  <= mod_sel ? 1 : 0;
        np_cnt  <= 1;
      end else begin
        sw_cnt <= sw_cnt + (mod_sel ? 1 : 0);
        np_cnt <= np_cnt + 1;
      end
    end
  end

  always @(posedge rf_clk) begin
    wd <= wd + 1;
    if (wd > 190000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act %0d exp %0d cycles", wd, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int n);
    int target = cyc_done + n;
    while (cyc_done < target) @(negedge rf_clk);
  endtask

  task automatic set_cfg(input int a, input int b, input int m);
    @(negedge rf_clk);
    a_in = 6'(a);
    b_in = 13'(b);
    m_in = 2'(m);
  endtask

  task automatic run_cfg(input int a, input int b, input int m);
    int p = 8 << m;
    int be = (b == 0) ? 1 : b;
    int swe = (a > be) ? be : a;
    int bad = (a > b || b == 0) ? 1 : 0;
    set_cfg(a, b, m);
    wait_done(2);
    for (int k = 0; k < 2; k++) begin
      wait_done(1);
      if (bad == 0) begin
        chk("R1 period", last_period, be * p + swe);
        chk("R2 swallow", last_sw, swe);
      end else begin
        chk("R7 period", last_period, be * p + swe);
        chk("R7 swallow", last_sw, swe);
      end
      chk("R3 periods per cycle", last_np, be);
      chk("R6 err", int'(err), bad);
      chk("R4 mode", int'(mode_q), m);
    end
  endtask

  int pa[10] = '{0, 1, 0, 2, 1, 3, 5, 0, 7, 10};
  int pb[10] = '{1, 1, 2, 2, 3, 4, 7, 9, 9, 12};

  initial begin
    repeat (3) @(negedge rf_clk);
    // R8 reset values
    chk("R8 mod_sel", int'(mod_sel), 0);
    chk("R8 div", int'(div), 0);
    chk("R8 err", int'(err), 0);
    chk("R8 mode", int'(mode_q), 0);
    a_in = 6'd2; b_in = 13'd3; m_in = 2'd1;
    @(negedge rf_clk);
    rst_n = 1'b1;
    // R8 first edge loads the inputs present then
    wait_done(1);
    chk("R8 first cycle period", last_period, 3 * 16 + 2);

    // R1 R2 R3 R4 sweep over all modes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 10; i++) run_cfg(pa[i], pb[i], m);
    run_cfg(63, 63, 0);

    // R1 randomized legal values
    for (int i = 0; i < 8; i++) begin
      int b = 1 + $urandom_range(0, 15);
      int a = $urandom_range(0, b);
      run_cfg(a, b, $urandom_range(0, 3));
    end

    // R6 R7 illegal pairs, then recovery
    run_cfg(5, 3, 0);
    run_cfg(0, 0, 1);
    run_cfg(4, 0, 0);
    run_cfg(2, 6, 2);

    // R5 mid-cycle change keeps the cycle in flight
    run_cfg(3, 5, 0);
    wait_done(1);
    repeat (10) @(negedge rf_clk);
    a_in = 6'd1; b_in = 13'd2; m_in = 2'd1;
    @(negedge rf_clk);
    chk("R5 mode held mid-cycle", int'(mode_q), 0);
    chk("R5 err held mid-cycle", int'(err), 0);
    wait_done(1);
    chk("R5 old ratio kept", last_period, 5 * 8 + 3);
    wait_done(1);
    chk("R5 new ratio applied", last_period, 2 * 16 + 1);
    chk("R4 mode after boundary", int'(mode_q), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule